// File: doc/BRIEF.md
# Fetch-Stage Branch Direction and Return Predictor

This block sits in the fetch stage and turns the address being fetched into a guess about what comes next. It returns a taken flag, a next fetch address, and a 2-bit code telling which mechanism produced the guess. The front end supplies the decoded kind of the instruction, whether its displacement points backward, the decoded branch destination, its length and any software direction hint. Retirement feeds resolved outcomes back into a small direct-mapped target table.

The target table holds a tag, a 2-bit saturating counter and a destination per slot. It is indexed by the low address bits and tagged with the rest. When the table has nothing for the address, a fixed rule decides the direction: backward branches are taken and forward branches fall through. A software hint replaces that rule. Calls push their return address onto a 16-deep circular stack, and returns pop it. All predictions are combinational within the lookup cycle. State changes (stack push or pop, table write) take effect at the next rising clock edge.

Top module: `fetch_dir_predictor`

## Requirements
- R1: For a conditional branch (kind 1) whose address has a valid slot with matching tag, the prediction is taken exactly when the slot's counter is 2 or 3. The address is the stored destination when taken and address plus length otherwise. The source code is 1.
- R2: A slot that is invalid or whose tag differs counts as a miss. A conditional branch that misses with a backward displacement and no hint is predicted taken to the decoded destination, with source code 2.
- R3: A conditional branch that misses with a forward displacement and no hint is predicted not taken to address plus length, with source code 2.
- R4: On a miss, a present hint decides the direction in place of the displacement rule, in either sense, with source code 2. On a hit the hint has no effect.
- R5: A resolved outcome whose address misses allocates that slot with counter 2 if taken or 1 if not. A hit steps the counter up on taken and down on not-taken, saturating at 3 and 0.
- R6: A call (kind 2) pushes address plus length. A return (kind 3) with a non-empty stack is predicted taken to the most recent pushed address, with source code 3, and pops it.
- R7: The stack holds 16 entries. A push while full overwrites the oldest entry, so after 17 calls only the 16 newest addresses come back, newest first, and the stack is then empty.
- R8: A return with an empty stack is predicted not taken to address plus length, with source code 0.
- R9: A non-branch (kind 0) always gets address plus length, not taken, source code 0, even when its address hits in the table.
- R10: After reset the table holds no valid slot and the stack is empty.
- R11: A call is always predicted taken: to the stored destination with source code 1 on a hit, otherwise to the decoded destination with source code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_vld | input | 1 | Lookup valid; gates stack push and pop |
| lk_pc | input | PC_W | Fetch address |
| lk_kind | input | 2 | Instruction kind: 0 none, 1 conditional, 2 call, 3 return |
| lk_len | input | LEN_W | Instruction length in bytes |
| lk_back | input | 1 | Displacement is negative |
| lk_dest | input | PC_W | Decoded branch destination |
| hint_vld | input | 1 | Software direction hint present |
| hint_take | input | 1 | Hinted direction, 1 = taken |
| rs_vld | input | 1 | Resolved-outcome update valid |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Resolved direction |
| rs_dest | input | PC_W | Resolved destination |
| pred_taken | output | 1 | Predicted taken |
| pred_dest | output | PC_W | Predicted next fetch address |
| pred_src | output | 2 | Source: 0 sequential, 1 table, 2 static or hint, 3 stack |

## Verification
The hardest cases to reach are the counter extremes and the stack wrap. Each needs a long chain of earlier events, and the ports show them only through later predictions. The bench walks one table slot through runs of same-direction outcomes past both saturation points, probing after each run. A down-step past zero that wrapped would later read as taken. The bench also issues seventeen calls before draining the stack, which exposes whether the oldest entry was dropped and whether the count stopped at sixteen.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam logic [1:0] KIND_NONE = 2'd0;
  localparam logic [1:0] KIND_COND = 2'd1;
  localparam logic [1:0] KIND_CALL = 2'd2;
  localparam logic [1:0] KIND_RET  = 2'd3;

  localparam logic [1:0] SRC_SEQ    = 2'd0;
  localparam logic [1:0] SRC_TABLE  = 2'd1;
  localparam logic [1:0] SRC_STATIC = 2'd2;
  localparam logic [1:0] SRC_STACK  = 2'd3;

  localparam logic [1:0] CTR_WEAK_NT = 2'd1;
  localparam logic [1:0] CTR_WEAK_T  = 2'd2;

  function automatic logic [1:0] sat_step(input logic [1:0] ctr, input logic up);
    if (up) return (ctr == 2'd3) ? 2'd3 : ctr + 2'd1;
    else    return (ctr == 2'd0) ? 2'd0 : ctr - 2'd1;
  endfunction
endpackage

// File: rtl/tgt_table.sv
module tgt_table #(
  parameter int PC_W  = 16,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] rd_pc,
  output logic            rd_hit,
  output logic [1:0]      rd_ctr,
  output logic [PC_W-1:0] rd_dest,
  input  logic            wr_vld,
  input  logic [PC_W-1:0] wr_pc,
  input  logic            wr_taken,
  input  logic [PC_W-1:0] wr_dest
);
  import pred_pkg::*;
  localparam int ENT   = 1 << IDX_W;
  localparam int TAG_W = PC_W - IDX_W;

  logic              vld_q  [ENT];
  logic [TAG_W-1:0]  tag_q  [ENT];
  logic [1:0]        ctr_q  [ENT];
  logic [PC_W-1:0]   dest_q [ENT];

  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [TAG_W-1:0]  rd_tag, wr_tag;
  logic              wr_hit;

  assign rd_idx  = rd_pc[IDX_W-1:0];
  assign rd_tag  = rd_pc[PC_W-1:IDX_W];
  assign wr_idx  = wr_pc[IDX_W-1:0];
  assign wr_tag  = wr_pc[PC_W-1:IDX_W];
  assign rd_hit  = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_ctr  = ctr_q[rd_idx];
  assign rd_dest = dest_q[rd_idx];
  assign wr_hit  = vld_q[wr_idx] && (tag_q[wr_idx] == wr_tag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENT; i++) begin
        vld_q[i]  <= 1'b0;
        tag_q[i]  <= '0;
        ctr_q[i]  <= '0;
        dest_q[i] <= '0;
      end
    end else if (wr_vld) begin
      if (wr_hit) begin
        ctr_q[wr_idx] <= sat_step(ctr_q[wr_idx], wr_taken);
        if (wr_taken) dest_q[wr_idx] <= wr_dest;
      end else begin
        vld_q[wr_idx]  <= 1'b1;
        tag_q[wr_idx]  <= wr_tag;
        ctr_q[wr_idx]  <= wr_taken ? CTR_WEAK_T : CTR_WEAK_NT;
        dest_q[wr_idx] <= wr_dest;
      end
    end
  end

  // R5: a missing address becomes a valid slot after the update
  assert_alloc_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld && !wr_hit |=> vld_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag)));
  // R5: taken at the top stays at the top
  assert_ctr_top_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld && wr_hit && wr_taken && (ctr_q[wr_idx] == 2'd3) |=> ctr_q[$past(wr_idx)] == 2'd3);
  // R5: not-taken at the bottom stays at the bottom
  assert_ctr_bot_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld && wr_hit && !wr_taken && (ctr_q[wr_idx] == 2'd0) |=> ctr_q[$past(wr_idx)] == 2'd0);
endmodule

// File: rtl/static_guess.sv
module static_guess (
  input  logic is_back,
  input  logic hint_vld,
  input  logic hint_take,
  output logic guess_take
);
  always_comb begin
    if (hint_vld) guess_take = hint_take;
    else          guess_take = is_back;
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_addr,
  output logic [ADDR_W-1:0] top_addr,
  output logic              empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  top_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              full;
  logic [PTR_W-1:0]  up_ptr, dn_ptr;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction
  function automatic logic [PTR_W-1:0] wrap_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - PTR_W'(1);
  endfunction

  assign up_ptr   = wrap_inc(top_q);
  assign dn_ptr   = wrap_dec(top_q);
  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == FULL_CNT);
  assign top_addr = mem_q[top_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= PTR_W'(DEPTH - 1);
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push) begin
      mem_q[up_ptr] <= push_addr;
      top_q <= up_ptr;
      if (!full) cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop && !empty) begin
      top_q <= dn_ptr;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R6: a pop on a non-empty stack removes exactly one entry
  assert_pop_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && !empty |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R6: the pushed address is on top afterwards
  assert_push_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> top_addr == $past(push_addr));
  // R7: pushing while full keeps the count at the depth
  assert_wrap_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push && full |=> full);
  // R10: empty right after reset
  assert_reset_empty_R10: assert property (@(posedge clk)
    !rst_n |=> empty || $past(push));
endmodule

// File: rtl/fetch_dir_predictor.sv
module fetch_dir_predictor #(
  parameter int PC_W      = 16,
  parameter int LEN_W     = 4,
  parameter int IDX_W     = 4,
  parameter int RAS_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_vld,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic [1:0]       lk_kind,
  input  logic [LEN_W-1:0] lk_len,
  input  logic             lk_back,
  input  logic [PC_W-1:0]  lk_dest,
  input  logic             hint_vld,
  input  logic             hint_take,
  input  logic             rs_vld,
  input  logic [PC_W-1:0]  rs_pc,
  input  logic             rs_taken,
  input  logic [PC_W-1:0]  rs_dest,
  output logic             pred_taken,
  output logic [PC_W-1:0]  pred_dest,
  output logic [1:0]       pred_src
);
  import pred_pkg::*;

  function automatic logic [PC_W-1:0] seq_next(input logic [PC_W-1:0] pc,
                                               input logic [LEN_W-1:0] len);
    return pc + PC_W'(len);
  endfunction

  logic            tbl_hit;
  logic [1:0]      tbl_ctr;
  logic [PC_W-1:0] tbl_dest;
  logic            fixed_take;
  logic            stk_push, stk_pop, stk_empty;
  logic [PC_W-1:0] stk_top;
  logic [PC_W-1:0] seq_pc;

  assign seq_pc = seq_next(lk_pc, lk_len);

  tgt_table #(.PC_W(PC_W), .IDX_W(IDX_W)) table_i (
    .clk(clk), .rst_n(rst_n),
    .rd_pc(lk_pc), .rd_hit(tbl_hit), .rd_ctr(tbl_ctr), .rd_dest(tbl_dest),
    .wr_vld(rs_vld), .wr_pc(rs_pc), .wr_taken(rs_taken), .wr_dest(rs_dest)
  );

  static_guess guess_i (
    .is_back(lk_back), .hint_vld(hint_vld), .hint_take(hint_take),
    .guess_take(fixed_take)
  );

  assign stk_push = lk_vld && (lk_kind == KIND_CALL);
  assign stk_pop  = lk_vld && (lk_kind == KIND_RET) && !stk_empty;

  ret_stack #(.DEPTH(RAS_DEPTH), .ADDR_W(PC_W)) stack_i (
    .clk(clk), .rst_n(rst_n),
    .push(stk_push), .pop(stk_pop), .push_addr(seq_pc),
    .top_addr(stk_top), .empty(stk_empty)
  );

  always_comb begin
    pred_taken = 1'b0;
    pred_dest  = seq_pc;
    pred_src   = SRC_SEQ;
    case (lk_kind)
      KIND_COND: begin
        if (tbl_hit) begin
          pred_taken = tbl_ctr[1];
          pred_dest  = tbl_ctr[1] ? tbl_dest : seq_pc;
          pred_src   = SRC_TABLE;
        end else begin
          pred_taken = fixed_take;
          pred_dest  = fixed_take ? lk_dest : seq_pc;
          pred_src   = SRC_STATIC;
        end
      end
      KIND_CALL: begin
        pred_taken = 1'b1;
        pred_dest  = tbl_hit ? tbl_dest : lk_dest;
        pred_src   = tbl_hit ? SRC_TABLE : SRC_STATIC;
      end
      KIND_RET: begin
        if (!stk_empty) begin
          pred_taken = 1'b1;
          pred_dest  = stk_top;
          pred_src   = SRC_STACK;
        end
      end
      default: ;
    endcase
  end

  // R8: sequential source never claims taken
  assert_seq_not_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pred_src == SRC_SEQ |-> !pred_taken && pred_dest == seq_pc);
  // R6: the stack is the source only for a return with entries
  assert_stack_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pred_src == SRC_STACK |-> lk_kind == KIND_RET && !stk_empty);
  // R9: plain instructions never use the table
  assert_plain_seq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lk_kind == KIND_NONE |-> pred_src == SRC_SEQ);
  // R11: calls always redirect
  assert_call_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lk_kind == KIND_CALL |-> pred_taken);
  // R4: a hit ignores the hint and the displacement sign
  assert_hit_uses_table_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_kind == KIND_COND && tbl_hit |-> pred_src == SRC_TABLE && pred_taken == tbl_ctr[1]);
endmodule

// File: tb/fetch_dir_predictor_tb.sv
module fetch_dir_predictor_tb_top;
  localparam int PC_W = 16;
  localparam int LEN_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_vld = 1'b0;
  logic [PC_W-1:0] lk_pc = '0;
  logic [1:0] lk_kind = 2'd0;
  logic [LEN_W-1:0] lk_len = '0;
  logic lk_back = 1'b0;
  logic [PC_W-1:0] lk_dest = '0;
  logic hint_vld = 1'b0, hint_take = 1'b0;
  logic rs_vld = 1'b0;
  logic [PC_W-1:0] rs_pc = '0;
  logic rs_taken = 1'b0;
  logic [PC_W-1:0] rs_dest = '0;
  logic pred_taken;
  logic [PC_W-1:0] pred_dest;
  logic [1:0] pred_src;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fetch_dir_predictor dut_i (
    .clk(clk), .rst_n(rst_n), .lk_vld(lk_vld), .lk_pc(lk_pc), .lk_kind(lk_kind),
    .lk_len(lk_len), .lk_back(lk_back), .lk_dest(lk_dest), .hint_vld(hint_vld),
    .hint_take(hint_take), .rs_vld(rs_vld), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .rs_dest(rs_dest), .pred_taken(pred_taken), .pred_dest(pred_dest), .pred_src(pred_src)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic        back;
    logic        hv;
    logic        ht;
    logic [15:0] pc;
    logic [15:0] dest;
    logic [3:0]  len;
    logic        e_tk;
    logic [15:0] e_dest;
    logic [1:0]  e_src;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 16'h0100, 16'h0000, 4'd4,  1'b0, 16'h0104, 2'd0}, // R9
    '{2'd1, 1'b1, 1'b0, 1'b0, 16'h0200, 16'h01F0, 4'd2,  1'b1, 16'h01F0, 2'd2}, // R2
    '{2'd1, 1'b0, 1'b0, 1'b0, 16'h0300, 16'h0340, 4'd4,  1'b0, 16'h0304, 2'd2}, // R3
    '{2'd1, 1'b0, 1'b1, 1'b1, 16'h0300, 16'h0340, 4'd4,  1'b1, 16'h0340, 2'd2}, // R4
    '{2'd1, 1'b1, 1'b1, 1'b0, 16'h0200, 16'h01F0, 4'd2,  1'b0, 16'h0202, 2'd2}, // R4
    '{2'd3, 1'b0, 1'b0, 1'b0, 16'h0400, 16'h0000, 4'd1,  1'b0, 16'h0401, 2'd0}, // R8
    '{2'd1, 1'b0, 1'b0, 1'b0, 16'h0FF8, 16'h1100, 4'd15, 1'b0, 16'h1007, 2'd0}  // R3 (src fixed below)
  };

  task automatic look(input logic [1:0] kind, input logic [15:0] pc, input logic [3:0] len,
                      input logic back, input logic [15:0] dest, input logic hv, input logic ht,
                      input logic e_tk, input logic [15:0] e_dest, input logic [1:0] e_src,
                      input string req);
    @(negedge clk);
    rs_vld = 1'b0;
    lk_vld = 1'b1; lk_kind = kind; lk_pc = pc; lk_len = len; lk_back = back;
    lk_dest = dest; hint_vld = hv; hint_take = ht;
    #2;
    checks++;
    if (pred_taken !== e_tk || pred_dest !== e_dest || pred_src !== e_src) begin
      errors++;
      $display("FAIL %s pc=%h actual tk=%0b dest=%h src=%0d expected tk=%0b dest=%h src=%0d",
               req, pc, pred_taken, pred_dest, pred_src, e_tk, e_dest, e_src);
    end
  endtask

  task automatic resolve(input logic [15:0] pc, input logic tk, input logic [15:0] dest);
    @(negedge clk);
    lk_vld = 1'b0; lk_kind = 2'd0;
    rs_vld = 1'b1; rs_pc = pc; rs_taken = tk; rs_dest = dest;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10: fresh state -> miss and empty stack
    look(2'd1, 16'h0500, 4'd4, 1'b0, 16'h0700, 1'b0, 1'b0, 1'b0, 16'h0504, 2'd2, "R10 table empty");
    look(2'd3, 16'h0500, 4'd4, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0504, 2'd0, "R10 stack empty");

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      logic [1:0] es = (v.kind == 2'd1) ? 2'd2 : v.e_src;
      look(v.kind, v.pc, v.len, v.back, v.dest, v.hv, v.ht, v.e_tk, v.e_dest, es,
           "R2/R3/R4/R8/R9 table");
    end

    // R5 allocate taken -> counter 2, R1 hit
    resolve(16'h0500, 1'b1, 16'h0700);
    look(2'd1, 16'h0500, 4'd4, 1'b0, 16'h0999, 1'b0, 1'b0, 1'b1, 16'h0700, 2'd1, "R1 R5 alloc taken");
    look(2'd0, 16'h0500, 4'd4, 1'b0, 16'h0999, 1'b0, 1'b0, 1'b0, 16'h0504, 2'd0, "R9 plain on hit");
    // R2 tag mismatch at same index
    look(2'd1, 16'h1500, 4'd4, 1'b1, 16'h1400, 1'b0, 1'b0, 1'b1, 16'h1400, 2'd2, "R2 tag mismatch");
    // counter 2 -> 1: not taken
    resolve(16'h0500, 1'b0, 16'h0000);
    look(2'd1, 16'h0500, 4'd4, 1'b1, 16'h0999, 1'b1, 1'b1, 1'b0, 16'h0504, 2'd1, "R1 R4 hint ignored on hit");
    // 1 ->0 ->0 ->0 then taken ->1: still not taken
    resolve(16'h0500, 1'b0, 16'h0000);
    resolve(16'h0500, 1'b0, 16'h0000);
    resolve(16'h0500, 1'b0, 16'h0000);
    resolve(16'h0500, 1'b1, 16'h0710);
    look(2'd1, 16'h0500, 4'd4, 1'b0, 16'h0999, 1'b0, 1'b0, 1'b0, 16'h0504, 2'd1, "R5 bottom saturation");
    // 1 -> 2,3,3,3 then not taken -> 2: taken to latest dest
    resolve(16'h0500, 1'b1, 16'h0720);
    resolve(16'h0500, 1'b1, 16'h0720);
    resolve(16'h0500, 1'b1, 16'h0720);
    resolve(16'h0500, 1'b1, 16'h0720);
    resolve(16'h0500, 1'b0, 16'h0000);
    look(2'd1, 16'h0500, 4'd4, 1'b0, 16'h0999, 1'b0, 1'b0, 1'b1, 16'h0720, 2'd1, "R5 top saturation");
    // R5 allocate not taken -> counter 1 overrides backward rule
    resolve(16'h0608, 1'b0, 16'h0800);
    look(2'd1, 16'h0608, 4'd2, 1'b1, 16'h0500, 1'b0, 1'b0, 1'b0, 16'h060A, 2'd1, "R5 alloc not taken");

    // R11 call miss, R6 return
    look(2'd2, 16'h2000, 4'd4, 1'b0, 16'h3000, 1'b0, 1'b0, 1'b1, 16'h3000, 2'd2, "R11 call miss");
    look(2'd2, 16'h3000, 4'd3, 1'b0, 16'h5000, 1'b0, 1'b0, 1'b1, 16'h5000, 2'd2, "R11 nested call");
    look(2'd3, 16'h5010, 4'd2, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h3003, 2'd3, "R6 return inner");
    look(2'd3, 16'h3010, 4'd2, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h2004, 2'd3, "R6 return outer");
    look(2'd3, 16'h2010, 4'd2, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h2012, 2'd0, "R8 drained");

    // R11 call hit
    resolve(16'h0505, 1'b1, 16'h0900);
    look(2'd2, 16'h0505, 4'd4, 1'b0, 16'h7777, 1'b0, 1'b0, 1'b1, 16'h0900, 2'd1, "R11 call hit");
    look(2'd3, 16'h0910, 4'd1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 16'h0509, 2'd3, "R6 return after hit call");

    // R7 overflow: 17 calls, 16 returns come back newest first, then empty
    for (int i = 0; i < 17; i++) begin
      logic [15:0] p = 16'h4000 + 16'(i * 16);
      look(2'd2, p, 4'd4, 1'b0, 16'h6000, 1'b0, 1'b0, 1'b1, 16'h6000, 2'd2, "R7 call fill");
    end
    for (int i = 16; i >= 1; i--) begin
      logic [15:0] e = 16'h4004 + 16'(i * 16);
      look(2'd3, 16'h6000, 4'd1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, e, 2'd3, "R7 drain order");
    end
    look(2'd3, 16'h6000, 4'd1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h6001, 2'd0, "R7 oldest dropped");

    @(negedge clk);
    lk_vld = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule